// File: doc/BRIEF.md
# Endpoint Control and Status Register Bank for a Low-Speed USB Device

This block is the register file that a small 8-bit controller uses to steer a three-endpoint, low-speed USB serial engine. For each endpoint it keeps a transmit configuration byte: the byte count for the next IN packet, a stall request, the data toggle to send, and an IN-ready flag. It also keeps the receive status of the control endpoint, the 7-bit device address, a bus control byte and the endpoint interrupt flags and enables. Its output is one combined interrupt request.

The controller reads and writes the registers through a plain port. The read port is combinational and the write port is a single-cycle strobe. The serial engine sends one-cycle event pulses into the block. These pulses clear the handshake bits on their own. A SETUP clears every stall request, and it also clears the IN-ready flag of the control endpoint. The IN-ready flags of the two data endpoints clear instead when the host returns an ACK. A bus reset returns the device address, the handshake bits and the interrupt flags to zero. When a hardware event and a controller write fall in the same cycle, the hardware event decides the bits it touches.

Top module: `usb_ep_regbank`

## Requirements
- R1: The register select `cpu_sel` maps 0/1/2 to the transmit bytes of endpoints 0/1/2, 3 to the control endpoint receive status, 4 to the device address, 5 to bus control and 6 to interrupts. Select 7 reads as 0. Each transmit byte holds the IN byte count in bits 3..0, a per-endpoint bit in bit 4 (the enable for endpoints 1 and 2, the error flag for endpoint 0), stall in bit 5, toggle select in bit 6 and IN-ready in bit 7. The transmit bytes read back exactly what was written, and every register is 0 after reset.
- R2: A SETUP pulse clears bit 5 of all three transmit bytes and bit 7 of the endpoint 0 transmit byte. The result is visible one cycle later.
- R3: An ACK pulse for endpoint 1 or 2 (`sie_ack[1]`, `sie_ack[2]`) clears bit 7 of that endpoint's transmit byte. `sie_ack[0]` leaves endpoint 0 unchanged.
- R4: A data error pulse sets bit 4 of the endpoint 0 transmit byte.
- R5: In the receive status register, a SETUP pulse sets bit 0, an OUT pulse sets bit 1 and an IN pulse sets bit 2. A SETUP or OUT pulse also loads `sie_rx_toggle` into bit 3 and `sie_rx_count` into bits 7..4. The controller can write the whole register.
- R6: The device address register stores bits 6..0 of a write, and bit 7 reads as 0. The address is driven on `dev_addr`.
- R7: Bus control bit 0 (bus activity) is set by an activity pulse. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R8: Bus control bits 1 (force K), 2 (force J), 3 (control read enable) and 4 (control write enable) are read/write, and bits 7..5 read as 0. `force_k` and `force_j` follow bits 1 and 2.
- R9: The interrupt register holds endpoint flags in bits 2..0 and their enables in bits 6..4, and bits 3 and 7 read as 0. A completion pulse `sie_done[i]` sets flag i. Writing 0 to a flag clears it, writing 1 leaves it unchanged, and the enables are plain read/write.
- R10: `ep_irq` is high exactly when some flag and its matching enable are both 1.
- R11: A bus reset pulse clears the device address, every stall and IN-ready bit, and all interrupt flags.
- R12: When a controller write and a hardware set or clear event hit the same bit in the same cycle, the hardware event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_sel | input | 3 | Register select |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data |
| sie_setup | input | 1 | SETUP received pulse |
| sie_out | input | 1 | OUT received pulse |
| sie_in | input | 1 | IN received pulse |
| sie_rx_toggle | input | 1 | Received data toggle |
| sie_rx_count | input | 4 | Received byte count |
| sie_ack | input | 3 | ACK received, one bit per endpoint |
| sie_data_err | input | 1 | Received data error pulse |
| sie_activity | input | 1 | Bus activity pulse |
| sie_bus_reset | input | 1 | USB bus reset pulse |
| sie_done | input | 3 | Endpoint completion pulses |
| dev_addr | output | 7 | Device address |
| force_k | output | 1 | Force K line state |
| force_j | output | 1 | Force J line state |
| ep_irq | output | 1 | Combined endpoint interrupt request |

## Verification
Every register sits one edge after its cause. A write or an engine pulse is driven on a falling edge and held for one rising edge. The bench then reads the register back through the combinational read port shortly after the following falling edge, so each result is sampled exactly one cycle after its stimulus. `ep_irq` is derived from registered flags and enables, so it is checked in the same window as the interrupt register. The same-cycle conflict cases drive the write and the pulse in one cycle and read back in that same window.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int NUM_EP  = 3;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 3;
  localparam int CNT_W   = 4;
  localparam int ADDR_W  = 7;
  localparam int CTL_W   = 5;

  // bit positions inside a transmit configuration byte
  localparam int TX_BIT_AUX   = 4;
  localparam int TX_BIT_STALL = 5;
  localparam int TX_BIT_TOG   = 6;
  localparam int TX_BIT_INRDY = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_TX0    = 3'd0,
    SEL_TX1    = 3'd1,
    SEL_TX2    = 3'd2,
    SEL_RXSTAT = 3'd3,
    SEL_ADDR   = 3'd4,
    SEL_BUSCTL = 3'd5,
    SEL_IRQ    = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  // a bit that the controller may only clear: it survives where the write has a 1
  function automatic logic [NUM_EP-1:0] clear_only(input logic [NUM_EP-1:0] cur,
                                                   input logic [NUM_EP-1:0] wmask);
    return cur & wmask;
  endfunction

  function automatic logic any_pending(input logic [NUM_EP-1:0] flags,
                                       input logic [NUM_EP-1:0] ens);
    return |(flags & ens);
  endfunction
endpackage

// File: rtl/ep_txcfg_reg.sv
module ep_txcfg_reg
  import usb_ep_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              setup_evt,
  input  logic              ack_evt,
  input  logic              err_evt,
  input  logic              bus_rst,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = wr_en ? wdata : q;
    if (setup_evt) nxt[TX_BIT_STALL] = 1'b0;
    if (IS_CTRL) begin
      if (setup_evt) nxt[TX_BIT_INRDY] = 1'b0;
      if (err_evt)   nxt[TX_BIT_AUX]   = 1'b1;
    end else begin
      if (ack_evt)   nxt[TX_BIT_INRDY] = 1'b0;
    end
    if (bus_rst) begin
      nxt[TX_BIT_STALL] = 1'b0;
      nxt[TX_BIT_INRDY] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/usb_dev_regs.sv
module usb_dev_regs
  import usb_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_rx,
  input  logic              wr_addr,
  input  logic              wr_ctl,
  input  logic              setup_evt,
  input  logic              out_evt,
  input  logic              in_evt,
  input  logic              rx_toggle,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              activity,
  input  logic              bus_rst,
  output logic [DATA_W-1:0] rxstat_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CTL_W-1:0]  ctl_q
);
  logic [DATA_W-1:0] rx_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [CTL_W-1:0]  ctl_nxt;

  always_comb begin
    rx_nxt = wr_rx ? wdata : rxstat_q;
    if (setup_evt) rx_nxt[0] = 1'b1;
    if (out_evt)   rx_nxt[1] = 1'b1;
    if (in_evt)    rx_nxt[2] = 1'b1;
    if (setup_evt || out_evt) begin
      rx_nxt[3]   = rx_toggle;
      rx_nxt[7:4] = rx_count;
    end

    addr_nxt = wr_addr ? wdata[ADDR_W-1:0] : addr_q;
    if (bus_rst) addr_nxt = '0;

    ctl_nxt = ctl_q;
    if (wr_ctl) begin
      ctl_nxt[CTL_W-1:1] = wdata[CTL_W-1:1];
      ctl_nxt[0]         = ctl_q[0] & wdata[0];
    end
    if (activity) ctl_nxt[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxstat_q <= '0;
      addr_q   <= '0;
      ctl_q    <= '0;
    end else begin
      rxstat_q <= rx_nxt;
      addr_q   <= addr_nxt;
      ctl_q    <= ctl_nxt;
    end
  end
endmodule

// File: rtl/ep_irq_unit.sv
module ep_irq_unit
  import usb_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_EP-1:0] done,
  input  logic              bus_rst,
  output logic [NUM_EP-1:0] flags_q,
  output logic [NUM_EP-1:0] ens_q,
  output logic              irq
);
  logic [NUM_EP-1:0] flags_nxt;
  logic [NUM_EP-1:0] ens_nxt;

  always_comb begin
    flags_nxt = wr_en ? clear_only(flags_q, wdata[NUM_EP-1:0]) : flags_q;
    ens_nxt   = wr_en ? wdata[4 +: NUM_EP] : ens_q;
    flags_nxt = flags_nxt | done;
    if (bus_rst) flags_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ens_q   <= '0;
    end else begin
      flags_q <= flags_nxt;
      ens_q   <= ens_nxt;
    end
  end

  assign irq = any_pending(flags_q, ens_q);
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
  import usb_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cpu_sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sie_setup,
  input  logic              sie_out,
  input  logic              sie_in,
  input  logic              sie_rx_toggle,
  input  logic [CNT_W-1:0]  sie_rx_count,
  input  logic [NUM_EP-1:0] sie_ack,
  input  logic              sie_data_err,
  input  logic              sie_activity,
  input  logic              sie_bus_reset,
  input  logic [NUM_EP-1:0] sie_done,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              force_k,
  output logic              force_j,
  output logic              ep_irq
);
  logic [DATA_W-1:0] tx_q [NUM_EP];
  logic [NUM_EP-1:0] tx_wr;
  logic [NUM_EP-1:0] stall_vec;
  logic [NUM_EP-1:0] inrdy_vec;
  logic [DATA_W-1:0] rxstat_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [NUM_EP-1:0] irq_flags;
  logic [NUM_EP-1:0] irq_ens;
  logic              irq_wr;
  logic              busact;

  assign irq_wr = cpu_wr && (cpu_sel == SEL_IRQ);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EP; gi++) begin : g_ep
      assign tx_wr[gi] = cpu_wr && (cpu_sel == SEL_W'(gi));
      ep_txcfg_reg #(.IS_CTRL(gi == 0)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tx_wr[gi]),
        .wdata     (cpu_wdata),
        .setup_evt (sie_setup),
        .ack_evt   (sie_ack[gi]),
        .err_evt   (sie_data_err),
        .bus_rst   (sie_bus_reset),
        .q         (tx_q[gi])
      );
      assign stall_vec[gi] = tx_q[gi][TX_BIT_STALL];
      assign inrdy_vec[gi] = tx_q[gi][TX_BIT_INRDY];
    end
  endgenerate

  usb_dev_regs u_dev (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (cpu_wdata),
    .wr_rx     (cpu_wr && (cpu_sel == SEL_RXSTAT)),
    .wr_addr   (cpu_wr && (cpu_sel == SEL_ADDR)),
    .wr_ctl    (cpu_wr && (cpu_sel == SEL_BUSCTL)),
    .setup_evt (sie_setup),
    .out_evt   (sie_out),
    .in_evt    (sie_in),
    .rx_toggle (sie_rx_toggle),
    .rx_count  (sie_rx_count),
    .activity  (sie_activity),
    .bus_rst   (sie_bus_reset),
    .rxstat_q  (rxstat_q),
    .addr_q    (dev_addr),
    .ctl_q     (ctl_q)
  );

  ep_irq_unit u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (irq_wr),
    .wdata   (cpu_wdata),
    .done    (sie_done),
    .bus_rst (sie_bus_reset),
    .flags_q (irq_flags),
    .ens_q   (irq_ens),
    .irq     (ep_irq)
  );

  assign busact  = ctl_q[0];
  assign force_k = ctl_q[1];
  assign force_j = ctl_q[2];

  always_comb begin
    unique case (cpu_sel)
      SEL_TX0:    cpu_rdata = tx_q[0];
      SEL_TX1:    cpu_rdata = tx_q[1];
      SEL_TX2:    cpu_rdata = tx_q[2];
      SEL_RXSTAT: cpu_rdata = rxstat_q;
      SEL_ADDR:   cpu_rdata = {1'b0, dev_addr};
      SEL_BUSCTL: cpu_rdata = {3'b000, ctl_q};
      SEL_IRQ:    cpu_rdata = {1'b0, irq_ens, 1'b0, irq_flags};
      default:    cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_ep_regbank_chk.sv
module usb_ep_regbank_chk
  import usb_ep_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  cpu_sel,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              sie_setup,
  input logic [NUM_EP-1:0] sie_ack,
  input logic              sie_activity,
  input logic              sie_bus_reset,
  input logic [NUM_EP-1:0] sie_done,
  input logic [NUM_EP-1:0] stall_vec,
  input logic [NUM_EP-1:0] inrdy_vec,
  input logic              busact,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [NUM_EP-1:0] irq_flags,
  input logic [NUM_EP-1:0] irq_ens,
  input logic              irq_wr,
  input logic              ep_irq
);
  // R2
  setup_clears_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup |=> (stall_vec == '0) && !inrdy_vec[0]);
  // R3
  ack1_clears_inrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sie_ack[1] |=> !inrdy_vec[1]);
  // R3
  ack2_clears_inrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sie_ack[2] |=> !inrdy_vec[2]);
  // R7
  activity_sets_busact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sie_activity |=> busact);
  // R11
  bus_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sie_bus_reset |=> (dev_addr == '0) && (irq_flags == '0) && (stall_vec == '0) && (inrdy_vec == '0));
  // R10
  done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_done[0] && irq_ens[0] && !irq_wr && !sie_bus_reset) |=> ep_irq);
  // R6
  addr_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel == SEL_ADDR) |-> !cpu_rdata[7]);
  // R9
  irq_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel == SEL_IRQ) |-> (!cpu_rdata[7] && !cpu_rdata[3]));
endmodule

bind usb_ep_regbank usb_ep_regbank_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_sel       (cpu_sel),
  .cpu_rdata     (cpu_rdata),
  .sie_setup     (sie_setup),
  .sie_ack       (sie_ack),
  .sie_activity  (sie_activity),
  .sie_bus_reset (sie_bus_reset),
  .sie_done      (sie_done),
  .stall_vec     (stall_vec),
  .inrdy_vec     (inrdy_vec),
  .busact        (busact),
  .dev_addr      (dev_addr),
  .irq_flags     (irq_flags),
  .irq_ens       (irq_ens),
  .irq_wr        (irq_wr),
  .ep_irq        (ep_irq)
);

// File: tb/tb_usb_ep_regbank.sv
module tb_usb_ep_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cpu_sel = '0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       sie_setup = 1'b0, sie_out = 1'b0, sie_in = 1'b0;
  logic       sie_rx_toggle = 1'b0;
  logic [3:0] sie_rx_count = '0;
  logic [2:0] sie_ack = '0;
  logic       sie_data_err = 1'b0, sie_activity = 1'b0, sie_bus_reset = 1'b0;
  logic [2:0] sie_done = '0;
  logic [6:0] dev_addr;
  logic       force_k, force_j, ep_irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_ep_regbank dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive on the falling edge, hold through one rising edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 0; sie_setup = 0; sie_out = 0; sie_in = 0; sie_ack = '0;
    sie_data_err = 0; sie_activity = 0; sie_bus_reset = 0; sie_done = '0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    cpu_sel = s; cpu_wdata = d; cpu_wr = 1; step();
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    cpu_sel = s; #1; d = cpu_rdata;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] busv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state of all selects
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v); check("R1 reset", v, 8'h00);
    end
    check("R11 reset outputs", {dev_addr, ep_irq}, 8'h00);

    // R1 full write sweep of the three transmit bytes
    for (int e = 0; e < 3; e++)
      for (int d = 0; d < 256; d++) begin
        wr(3'(e), 8'(d)); rd(3'(e), v); check("R1 tx readback", v, 8'(d));
      end
    // R1 select 7 reads zero, and a write there changes nothing
    wr(3'd7, 8'hFF); rd(3'd7, v); check("R1 unused select", v, 8'h00);
    rd(3'd2, v); check("R1 unused write no effect", v, 8'hFF);

    // R2 setup clears stall everywhere and IN-ready of endpoint 0 only
    wr(3'd0, 8'hEF); wr(3'd1, 8'hF3); wr(3'd2, 8'hA1);
    sie_setup = 1; step();
    rd(3'd0, v); check("R2 ep0", v, 8'h4F);
    rd(3'd1, v); check("R2 ep1", v, 8'hD3);
    rd(3'd2, v); check("R2 ep2", v, 8'h81);

    // R3 ack clears IN-ready of endpoint 1 or 2, not endpoint 0
    wr(3'd0, 8'h85); wr(3'd1, 8'h96); wr(3'd2, 8'hC7);
    sie_ack = 3'b001; step();
    rd(3'd0, v); check("R3 ack0 ignored", v, 8'h85);
    sie_ack = 3'b010; step();
    rd(3'd1, v); check("R3 ack1", v, 8'h16);
    rd(3'd2, v); check("R3 ack1 leaves ep2", v, 8'hC7);
    sie_ack = 3'b100; step();
    rd(3'd2, v); check("R3 ack2", v, 8'h47);

    // R4 data error sets endpoint 0 bit 4
    wr(3'd0, 8'h03); sie_data_err = 1; step();
    rd(3'd0, v); check("R4 error flag", v, 8'h13);

    // R5 receive status
    wr(3'd3, 8'h00);
    sie_setup = 1; sie_rx_toggle = 0; sie_rx_count = 4'd8; step();
    rd(3'd3, v); check("R5 setup", v, 8'h81);
    sie_out = 1; sie_rx_toggle = 1; sie_rx_count = 4'd3; step();
    rd(3'd3, v); check("R5 out", v, 8'h3B);
    sie_in = 1; sie_rx_count = 4'd9; step();
    rd(3'd3, v); check("R5 in keeps count", v, 8'h3F);
    wr(3'd3, 8'h00); rd(3'd3, v); check("R5 cpu write", v, 8'h00);

    // R6 address sweep
    for (int d = 0; d < 256; d++) begin
      wr(3'd4, 8'(d)); rd(3'd4, v); check("R6 address", v, 8'(d) & 8'h7F);
      check("R6 dev_addr pins", {1'b0, dev_addr}, 8'(d) & 8'h7F);
    end

    // R7 R8 bus control sweep, with activity before every other write
    busv = 0;
    for (int d = 0; d < 256; d++) begin
      if (d % 2 == 0) begin
        sie_activity = 1; step(); busv = 1;
      end
      wr(3'd5, 8'(d));
      busv = busv & 8'(d & 1);
      rd(3'd5, v);
      check("R7 R8 bus control", v, (8'(d) & 8'h1E) | busv);
      check("R8 force pins", {6'b0, force_j, force_k}, 8'((d >> 1) & 3));
    end

    // R9 R10 interrupt sweep over every flag/enable pair
    for (int f = 0; f < 8; f++)
      for (int e = 0; e < 8; e++) begin
        wr(3'd6, 8'(e << 4));
        sie_done = 3'(f); step();
        rd(3'd6, v); check("R9 flags set", v, 8'((e << 4) | f));
        check("R10 irq", {7'b0, ep_irq}, {7'b0, (f & e) != 0});
        wr(3'd6, 8'((e << 4) | 7 | 8'h88));
        rd(3'd6, v); check("R9 write 1 keeps", v, 8'((e << 4) | f));
      end

    // R11 bus reset
    wr(3'd4, 8'h2A); wr(3'd1, 8'hFF); wr(3'd6, 8'h70); sie_done = 3'b111; step();
    sie_bus_reset = 1; step();
    rd(3'd4, v); check("R11 address", v, 8'h00);
    rd(3'd1, v); check("R11 ep1", v, 8'h5F);
    rd(3'd6, v); check("R11 flags", v, 8'h70);
    check("R11 irq", {7'b0, ep_irq}, 8'h00);

    // R12 hardware wins over a same-cycle write
    cpu_sel = 3'd1; cpu_wdata = 8'hFF; cpu_wr = 1; sie_ack = 3'b010; step();
    rd(3'd1, v); check("R12 ack vs write", v, 8'h7F);
    cpu_sel = 3'd4; cpu_wdata = 8'h55; cpu_wr = 1; sie_bus_reset = 1; step();
    rd(3'd4, v); check("R12 reset vs write", v, 8'h00);
    wr(3'd6, 8'h10);
    cpu_sel = 3'd6; cpu_wdata = 8'h10; cpu_wr = 1; sie_done = 3'b001; step();
    rd(3'd6, v); check("R12 done vs clear", v, 8'h11);
    cpu_sel = 3'd5; cpu_wdata = 8'h00; cpu_wr = 1; sie_activity = 1; step();
    rd(3'd5, v); check("R12 activity vs clear", v, 8'h01);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule